// File: doc/BRIEF.md
# Low-Leakage Wakeup Unit

This block watches a set of external wakeup pins, the device reset pin and a handful of internal peripheral wakeup requests. While the power-mode input reports one of the low-leakage modes, it raises a wakeup request toward the power controller. It also reports whether the exit must go through the reset flow. The reset pin always leaves a low-leakage mode that way. The deep low-leakage modes also leave that way on any wakeup.

Pin wakeups pass through a two-flop synchronizer and a per-pin edge selector. Each accepted edge sets a local sticky flag. These flags, and an overrun error flag, are cleared only by power-on reset or by a software write of one. A system reset leaves them intact, so software can find out what woke the device. Peripheral requests are not stored here. They are gated by a per-source enable and pass straight through, and they fall as soon as the peripheral drops them. A four-state controller tracks the mode: RUN, ARMED, WAKE and PINRST. In RUN, detection is off. ARMED means a low-leakage mode is active and no event has arrived yet. WAKE means a wakeup source is active. PINRST means the reset pin was seen low.

The controller moves RUN→ARMED when a low-leakage mode is entered. It moves ARMED→PINRST when the reset pin goes low, and that transition has priority over ARMED→WAKE, which happens on any enabled source. It moves WAKE→PINRST on the reset pin. Every state other than RUN returns to RUN as soon as the mode code leaves the low-leakage set.

Top module: `llwake_top`

## Requirements
- R1: Power-mode codes 4 (light low-leakage) and 5, 6, 7 (deep low-leakage) form the low-leakage set. Codes 0 to 3 are normal modes. Pin edges seen while the controller is in RUN never set a flag, and no stale edge is reported after entering a low-leakage mode.
- R2: Register 0 holds a 2-bit mode for pin p at bits [2p+1:2p]. The values are 00 off, 01 rising edge, 10 falling edge and 11 both edges. A selected edge sets bit p of the flag register (register 2).
- R3: Writing 1 to bit p of register 2 clears flag p. Writing 0 leaves the flag unchanged.
- R4: Pin flags and the error flag keep their value through sys_rst_n and are cleared by por_n. The configuration registers 0 and 1 are cleared by either reset.
- R5: The error flag (register 3, bit 0) sets when a selected edge arrives on a pin whose flag is already set. Writing 1 to bit 0 of register 3 clears it.
- R6: Peripheral requests are not stored. Their live value reads at register 3, bits [8+k], and wake_req follows them without any cycle of storage.
- R7: wake_req is high exactly when the mode is in the low-leakage set and either an enabled pin (mode not 00) has its flag set or a peripheral request is set with its enable bit (register 1, bit k) set.
- R8: A synchronized low level on rst_pin_n in any low-leakage mode asserts exit_via_reset. The output stays asserted after the pin is released and drops once the mode leaves the low-leakage set.
- R9: A pin or peripheral wakeup asserts exit_via_reset in the deep modes (5 to 7) but not in the light mode (4), where only wake_req rises.
- R10: A pin edge driven between clock edges reads in its flag after the third rising clock edge and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| por_n | input | 1 | Power-on reset, active low, clears everything |
| sys_rst_n | input | 1 | System reset, active low, spares the flags |
| pm_code | input | 3 | Current power-mode code |
| wk_pin | input | NUM_PINS | External wakeup pins, asynchronous |
| rst_pin_n | input | 1 | Device reset pin level, active low, asynchronous |
| mod_req | input | NUM_MODS | Internal peripheral wakeup requests |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register index 0 to 3 |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| wake_req | output | 1 | Wakeup request to the power controller |
| exit_via_reset | output | 1 | Exit from low-leakage mode goes through the reset flow |

## Verification
The bench builds the block with four pins and two peripheral sources. This makes the full cross of pin position, the four edge modes and both edge directions small enough to sweep completely, with the expected flag computed as a shift of one. The small count also lets the bench walk all eight power-mode codes against an enabled and a disabled peripheral source. It can then try each reset kind, the error flag, the reset-pin exit in light and deep modes, and the exact synchronizer latency in a few hundred cycles.

// File: rtl/llwake_pkg.sv
package llwake_pkg;

    // Controller states
    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_ARMED  = 2'd1,
        ST_WAKE   = 2'd2,
        ST_PINRST = 2'd3
    } wk_state_e;

    // Per-pin edge selection
    typedef enum logic [1:0] {
        EM_OFF  = 2'b00,
        EM_RISE = 2'b01,
        EM_FALL = 2'b10,
        EM_BOTH = 2'b11
    } edge_mode_e;

    localparam int PM_W = 3;
    localparam logic [PM_W-1:0] PM_LL_LIGHT = 3'd4;

    localparam int BUS_DW = 32;
    localparam int BUS_AW = 2;
    localparam logic [BUS_AW-1:0] RA_PINMODE = 2'd0;
    localparam logic [BUS_AW-1:0] RA_MODEN   = 2'd1;
    localparam logic [BUS_AW-1:0] RA_FLAGS   = 2'd2;
    localparam logic [BUS_AW-1:0] RA_STATUS  = 2'd3;
    localparam int STATUS_MOD_LSB = 8;

    function automatic logic is_low_leak(input logic [PM_W-1:0] code);
        return code[PM_W-1];
    endfunction

    function automatic logic is_deep(input logic [PM_W-1:0] code);
        return code[PM_W-1] && (code != PM_LL_LIGHT);
    endfunction

endpackage

// File: rtl/llwake_sync.sv
module llwake_sync #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            stab_q <= RST_VAL;
        end else begin
            meta_q <= d;
            stab_q <= meta_q;
        end
    end

    assign q = stab_q;

endmodule

// File: rtl/llwake_edge.sv
module llwake_edge
    import llwake_pkg::*;
#(
    parameter int NUM_PINS = 16,
    localparam int MW = 2 * NUM_PINS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_s,
    input  logic [MW-1:0]       pin_mode,
    output logic [NUM_PINS-1:0] hit
);

    logic [NUM_PINS-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= pin_s;
        end
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic       rise;
        logic       fall;
        edge_mode_e sel;

        assign rise = pin_s[p] & ~prev_q[p];
        assign fall = ~pin_s[p] & prev_q[p];
        assign sel  = edge_mode_e'(pin_mode[2*p +: 2]);

        always_comb begin
            unique case (sel)
                EM_OFF:  hit[p] = 1'b0;
                EM_RISE: hit[p] = rise;
                EM_FALL: hit[p] = fall;
                EM_BOTH: hit[p] = rise | fall;
            endcase
        end
    end

endmodule

// File: rtl/llwake_flags.sv
module llwake_flags #(
    parameter int NUM_PINS = 16
) (
    input  logic                clk,
    input  logic                por_n,
    input  logic                det_en,
    input  logic [NUM_PINS-1:0] hit,
    input  logic                clr_we,
    input  logic [NUM_PINS-1:0] clr_mask,
    input  logic                err_clr,
    output logic [NUM_PINS-1:0] flags,
    output logic                err
);

    logic [NUM_PINS-1:0] set_v;
    logic [NUM_PINS-1:0] kill_v;
    logic [NUM_PINS-1:0] flags_d;
    logic                err_d;

    always_comb begin
        set_v   = det_en ? hit : '0;
        kill_v  = clr_we ? clr_mask : '0;
        // a new edge outranks a clear arriving in the same cycle
        flags_d = (flags & ~kill_v) | set_v;
        err_d   = (err & ~err_clr) | (|(set_v & flags));
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            flags <= '0;
            err   <= 1'b0;
        end else begin
            flags <= flags_d;
            err   <= err_d;
        end
    end

endmodule

// File: rtl/llwake_fsm.sv
module llwake_fsm
    import llwake_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PM_W-1:0] pm_code,
    input  logic            wake_src,
    input  logic            rst_pin_lo,
    output logic            det_en,
    output logic            exit_via_reset,
    output wk_state_e       state
);

    wk_state_e st_q;
    wk_state_e st_d;
    logic      ll;

    assign ll = is_low_leak(pm_code);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_RUN;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RUN: begin
                if (ll) st_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (!ll)            st_d = ST_RUN;
                else if (rst_pin_lo) st_d = ST_PINRST;
                else if (wake_src)   st_d = ST_WAKE;
            end
            ST_WAKE: begin
                if (!ll)            st_d = ST_RUN;
                else if (rst_pin_lo) st_d = ST_PINRST;
            end
            ST_PINRST: begin
                if (!ll) st_d = ST_RUN;
            end
        endcase
    end

    always_comb begin
        det_en         = 1'b0;
        exit_via_reset = 1'b0;
        unique case (st_q)
            ST_RUN:    ;
            ST_ARMED:  det_en = 1'b1;
            ST_WAKE: begin
                det_en         = 1'b1;
                exit_via_reset = is_deep(pm_code);
            end
            ST_PINRST: begin
                det_en         = 1'b1;
                exit_via_reset = 1'b1;
            end
        endcase
    end

    assign state = st_q;

endmodule

// File: rtl/llwake_top.sv
module llwake_top
    import llwake_pkg::*;
#(
    parameter int NUM_PINS = 16,
    parameter int NUM_MODS = 7
) (
    input  logic                clk,
    input  logic                por_n,
    input  logic                sys_rst_n,
    input  logic [2:0]          pm_code,
    input  logic [NUM_PINS-1:0] wk_pin,
    input  logic                rst_pin_n,
    input  logic [NUM_MODS-1:0] mod_req,
    input  logic                bus_wr,
    input  logic [1:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic                wake_req,
    output logic                exit_via_reset
);

    localparam int MW = 2 * NUM_PINS;
    localparam int SW = NUM_PINS + 1;
    localparam logic [SW-1:0] SYNC_RST = {1'b1, {NUM_PINS{1'b0}}};

    logic                rst_n;
    logic [MW-1:0]       pin_mode_q;
    logic [NUM_MODS-1:0] mod_en_q;
    logic [SW-1:0]       sync_q;
    logic [NUM_PINS-1:0] pin_s;
    logic                rst_pin_lo;
    logic [NUM_PINS-1:0] hit;
    logic [NUM_PINS-1:0] pin_en;
    logic [NUM_PINS-1:0] pin_flags;
    logic                err_flag;
    logic                det_en;
    logic                wake_src;
    wk_state_e           fsm_st;
    logic                unused_wdata;

    assign rst_n        = por_n & sys_rst_n;
    assign unused_wdata = ^bus_wdata;

    // configuration registers, cleared by either reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_mode_q <= '0;
            mod_en_q   <= '0;
        end else if (bus_wr) begin
            if (bus_addr == RA_PINMODE) pin_mode_q <= bus_wdata[MW-1:0];
            if (bus_addr == RA_MODEN)   mod_en_q   <= bus_wdata[NUM_MODS-1:0];
        end
    end

    llwake_sync #(
        .W       (SW),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({rst_pin_n, wk_pin}),
        .q     (sync_q)
    );

    assign pin_s      = sync_q[NUM_PINS-1:0];
    assign rst_pin_lo = ~sync_q[NUM_PINS];

    llwake_edge #(
        .NUM_PINS (NUM_PINS)
    ) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_s    (pin_s),
        .pin_mode (pin_mode_q),
        .hit      (hit)
    );

    llwake_flags #(
        .NUM_PINS (NUM_PINS)
    ) u_flags (
        .clk      (clk),
        .por_n    (por_n),
        .det_en   (det_en),
        .hit      (hit),
        .clr_we   (bus_wr && (bus_addr == RA_FLAGS)),
        .clr_mask (bus_wdata[NUM_PINS-1:0]),
        .err_clr  (bus_wr && (bus_addr == RA_STATUS) && bus_wdata[0]),
        .flags    (pin_flags),
        .err      (err_flag)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_en
        assign pin_en[p] = |pin_mode_q[2*p +: 2];
    end

    assign wake_src = (|(pin_flags & pin_en)) | (|(mod_req & mod_en_q));
    assign wake_req = is_low_leak(pm_code) & wake_src;

    llwake_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .pm_code        (pm_code),
        .wake_src       (wake_src),
        .rst_pin_lo     (rst_pin_lo),
        .det_en         (det_en),
        .exit_via_reset (exit_via_reset),
        .state          (fsm_st)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            RA_PINMODE: bus_rdata[MW-1:0]       = pin_mode_q;
            RA_MODEN:   bus_rdata[NUM_MODS-1:0] = mod_en_q;
            RA_FLAGS:   bus_rdata[NUM_PINS-1:0] = pin_flags;
            RA_STATUS: begin
                bus_rdata[0]                         = err_flag;
                bus_rdata[STATUS_MOD_LSB +: NUM_MODS] = mod_req;
            end
        endcase
    end

endmodule

// File: rtl/llwake_chk.sv
module llwake_chk
    import llwake_pkg::*;
#(
    parameter int NUM_PINS = 16
) (
    input logic                clk,
    input logic                por_n,
    input logic                sys_rst_n,
    input logic [2:0]          pm_code,
    input logic                wake_req,
    input logic                exit_via_reset,
    input logic [NUM_PINS-1:0] flags,
    input logic                err,
    input wk_state_e           st,
    input logic                bus_wr,
    input logic [1:0]          bus_addr,
    input logic [NUM_PINS-1:0] wdata_lo
);

    p_no_wake_outside_ll_r7: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        !pm_code[2] |-> !wake_req);

    p_quiet_in_run_r1: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        (st == ST_RUN) |=> ((flags & ~$past(flags)) == '0));

    p_write_zero_keeps_r3: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        (bus_wr && bus_addr == RA_FLAGS && wdata_lo == '0 && st == ST_RUN) |=> (flags == $past(flags)));

    p_err_needs_flag_r5: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        $rose(err) |-> $past(|flags));

    p_pinrst_holds_r8: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        (st == ST_PINRST && pm_code[2]) |=> exit_via_reset);

    p_exit_from_ll_r9: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        exit_via_reset |-> $past(pm_code[2]));

endmodule

bind llwake_top llwake_chk #(
    .NUM_PINS (NUM_PINS)
) u_chk (
    .clk            (clk),
    .por_n          (por_n),
    .sys_rst_n      (sys_rst_n),
    .pm_code        (pm_code),
    .wake_req       (wake_req),
    .exit_via_reset (exit_via_reset),
    .flags          (pin_flags),
    .err            (err_flag),
    .st             (fsm_st),
    .bus_wr         (bus_wr),
    .bus_addr       (bus_addr),
    .wdata_lo       (bus_wdata[NUM_PINS-1:0])
);

// File: tb/tb_llwake_top.sv
module tb_llwake_top;

    localparam int NP = 4;
    localparam int NM = 2;

    logic          clk = 1'b0;
    logic          por_n = 1'b0;
    logic          sys_rst_n = 1'b0;
    logic [2:0]    pm_code = 3'd0;
    logic [NP-1:0] wk_pin = '0;
    logic          rst_pin_n = 1'b1;
    logic [NM-1:0] mod_req = '0;
    logic          bus_wr = 1'b0;
    logic [1:0]    bus_addr = 2'd0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          wake_req;
    logic          exit_via_reset;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    llwake_top #(.NUM_PINS(NP), .NUM_MODS(NM)) dut (
        .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .pm_code(pm_code),
        .wk_pin(wk_pin), .rst_pin_n(rst_pin_n), .mod_req(mod_req),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .wake_req(wake_req), .exit_via_reset(exit_via_reset)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic clear_all();
        wr(2'd2, 32'hFFFF_FFFF);
        wr(2'd3, 32'h1);
    endtask

    function automatic bit exp_hit(input int m, input bit rising);
        return (m == 3) || (m == 1 && rising) || (m == 2 && !rising);
    endfunction

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        cyc(3);
        por_n = 1'b1; sys_rst_n = 1'b1;
        cyc(3);

        // reset state, R4
        rd(2'd0, d); chk("R4 reset pinmode", d, 0);
        rd(2'd2, d); chk("R4 reset flags", d, 0);
        chk("R7 reset wake_req", {31'd0, wake_req}, 0);
        chk("R8 reset exit", {31'd0, exit_via_reset}, 0);

        // R2 sweep: pin x mode x direction, deep mode
        for (int p = 0; p < NP; p++) begin
            for (int m = 0; m < 4; m++) begin
                for (int r = 0; r < 2; r++) begin
                    pm_code = 3'd0;
                    wr(2'd0, 0);
                    wk_pin = (r == 1) ? '0 : '1;
                    cyc(6);
                    clear_all();
                    wr(2'd0, m << (2 * p));
                    pm_code = 3'd5;
                    cyc(3);
                    wk_pin[p] = ~wk_pin[p];
                    cyc(6);
                    rd(2'd2, d);
                    chk($sformatf("R2 pin%0d mode%0d rise%0d", p, m, r), d,
                        exp_hit(m, r == 1) ? (32'd1 << p) : 32'd0);
                    chk($sformatf("R7 pin%0d mode%0d rise%0d wake", p, m, r),
                        {31'd0, wake_req}, {31'd0, exp_hit(m, r == 1)});
                    pm_code = 3'd0;
                    cyc(3);
                end
            end
        end

        // R1: edges in normal modes are ignored, no stale edge after entry
        wk_pin = '0;
        wr(2'd0, 32'hFF);
        cyc(6);
        clear_all();
        for (int c = 0; c < 4; c++) begin
            pm_code = 3'(c);
            cyc(2);
            wk_pin = ~wk_pin;
            cyc(6);
            rd(2'd2, d);
            chk($sformatf("R1 code%0d ignored", c), d, 0);
        end
        pm_code = 3'd6;
        cyc(6);
        rd(2'd2, d); chk("R1 no stale edge", d, 0);
        pm_code = 3'd0;
        cyc(3);

        // R10 latency, pin 0 both edges, deep mode
        wr(2'd0, 32'h3);
        pm_code = 3'd5;
        cyc(3);
        bus_addr = 2'd2;
        @(negedge clk);
        wk_pin[0] = ~wk_pin[0];
        @(posedge clk); @(posedge clk);
        #1 chk("R10 not after 2 edges", bus_rdata, 0);
        @(posedge clk);
        #1 chk("R10 set after 3 edges", bus_rdata, 1);

        // R5 error flag and R3 write-one-to-clear
        rd(2'd3, d); chk("R5 no err single edge", d & 32'h1, 0);
        cyc(2);
        wk_pin[0] = ~wk_pin[0];
        cyc(6);
        rd(2'd3, d); chk("R5 err on second edge", d & 32'h1, 1);
        wr(2'd3, 32'h1);
        rd(2'd3, d); chk("R5 err cleared", d & 32'h1, 0);
        wr(2'd0, 32'h33);
        wk_pin[2] = ~wk_pin[2];
        cyc(6);
        rd(2'd2, d); chk("R3 two flags", d, 32'h5);
        pm_code = 3'd0;
        cyc(3);
        wr(2'd2, 32'h0);
        rd(2'd2, d); chk("R3 write zero keeps", d, 32'h5);
        wr(2'd2, 32'h1);
        rd(2'd2, d); chk("R3 write one clears", d, 32'h4);

        // R4: system reset keeps flags, clears config
        @(negedge clk); sys_rst_n = 1'b0;
        cyc(2); sys_rst_n = 1'b1;
        cyc(2);
        rd(2'd2, d); chk("R4 flags kept by sys reset", d, 32'h4);
        rd(2'd0, d); chk("R4 config cleared by sys reset", d, 0);
        @(negedge clk); por_n = 1'b0;
        cyc(2); por_n = 1'b1;
        cyc(4);
        rd(2'd2, d); chk("R4 flags cleared by por", d, 0);

        // R6/R7: peripheral requests across all power codes
        wr(2'd1, 32'h1);
        mod_req = 2'b01;
        for (int c = 0; c < 8; c++) begin
            pm_code = 3'(c);
            #1 chk($sformatf("R7 module code%0d", c), {31'd0, wake_req}, {31'd0, c >= 4});
            cyc(1);
        end
        pm_code = 3'd5;
        mod_req = 2'b10;
        #1 chk("R7 disabled module", {31'd0, wake_req}, 0);
        rd(2'd3, d); chk("R6 raw module status", (d >> 8) & 32'h3, 32'h2);
        mod_req = 2'b01;
        #1 chk("R6 passthrough rises", {31'd0, wake_req}, 1);
        mod_req = 2'b00;
        #1 chk("R6 passthrough drops", {31'd0, wake_req}, 0);
        pm_code = 3'd0;
        cyc(3);

        // R9: light vs deep module wake
        mod_req = 2'b01;
        pm_code = 3'd4;
        cyc(5);
        chk("R9 light wake req", {31'd0, wake_req}, 1);
        chk("R9 light no reset exit", {31'd0, exit_via_reset}, 0);
        pm_code = 3'd0; cyc(3);
        pm_code = 3'd7;
        cyc(5);
        chk("R9 deep reset exit", {31'd0, exit_via_reset}, 1);
        pm_code = 3'd0;
        mod_req = '0;
        cyc(3);
        chk("R9 exit drops on leave", {31'd0, exit_via_reset}, 0);

        // R8: reset pin
        rst_pin_n = 1'b0;
        cyc(5);
        chk("R8 pin ignored in run", {31'd0, exit_via_reset}, 0);
        rst_pin_n = 1'b1;
        cyc(4);
        pm_code = 3'd4;
        cyc(3);
        rst_pin_n = 1'b0;
        cyc(5);
        chk("R8 light pin exit", {31'd0, exit_via_reset}, 1);
        rst_pin_n = 1'b1;
        cyc(5);
        chk("R8 exit held", {31'd0, exit_via_reset}, 1);
        pm_code = 3'd0;
        cyc(2);
        chk("R8 exit released", {31'd0, exit_via_reset}, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule